// File: doc/BRIEF.md
# EEPROM Word Access and Ownership Semaphore Registers

This block is the host-facing register slice of a network controller that reaches a 64-word configuration EEPROM and arbitrates EEPROM ownership between host software and on-board firmware. Software writes a request word that holds a word address and a start flag. The block looks up the word in its preloaded array during that same write. It stores the result with a done flag, so the next read of the register returns it.

A second register carries a hardware-style semaphore bit. Reading that register returns its present value and then marks it taken, so only one reader can see it free. The software EEPROM claim bit in that register cannot be set while firmware holds its own claim. Firmware status is presented read-only from input pins. A 32-bit sync word gives plain scratch storage for the two agents.

The bus is a simple single-cycle register interface. Read data is combinational while the read strobe is high. Writes take effect at the rising clock edge.

Top module: `eeprom_sema_regs`

## Requirements
- R1: After reset, the EEPROM request register (byte offset 0x00), the software semaphore register (0x04) and the sync register (0x0C) all read 0.
- R2: A write to 0x00 with bit 0 (start) set stores bit 0 = 0, bit 1 (done) = 1, bits 15:2 = the written word address, and bits 31:16 = the addressed EEPROM word. The result is visible on the next read.
- R3: EEPROM word k for k in 0..62 is (0x1000 + k*0x0101) mod 2^16. Word 63 is the checksum, chosen so that the 64 words sum to 0xBABA mod 2^16.
- R4: A start request whose address is 64 or above returns data 0 and still sets done.
- R5: A write to 0x00 with bit 0 clear stores the written 32-bit value unchanged.
- R6: A read of 0x04 returns the current value, and from the following cycle bit 0 of that register is 1.
- R7: A write to 0x04 stores bits 2:0, and bits 31:3 always read 0. Bit 1 is stored as 0 whenever the firmware semaphore input is 1.
- R8: Offset 0x08 reads the firmware semaphore in bit 0, the firmware mode in bits 3:1 and the firmware reset count in bits 18:16, with all other bits 0. Writes to it have no effect.
- R9: Offset 0x0C is a 32-bit register that reads back the last value written.
- R10: Read data is 0 whenever the read strobe is low or the address matches no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 32 | Read data, valid while re_i is high |
| fw_sem_i | input | 1 | Firmware EEPROM semaphore held |
| fw_mode_i | input | 3 | Firmware mode |
| fw_rst_cnt_i | input | 3 | Firmware reset count |

## Verification
On every cycle, the assertions check the state change that follows each write or read strobe. This covers the start-to-done conversion and its stored address, zero data for out-of-range addresses, and plain storage when start is clear. It also covers the read-to-set semaphore, the firmware veto on the software claim bit, the sync register update, the firmware status view and the idle read bus. Only the bench scenarios can show that the returned EEPROM words have the right values and that the whole array sums to the checksum target. The same holds for a second semaphore reader seeing the bit taken, and for a mid-run reset clearing every register.

// File: rtl/eeprom_sema_pkg.sv
package eeprom_sema_pkg;
  localparam int DATA_W    = 32;
  localparam int WORD_W    = 16;
  localparam int EE_AW     = 14;          // address field bits 15:2
  localparam int EE_DEPTH  = 64;
  localparam logic [WORD_W-1:0] EE_BASE   = 16'h1000;
  localparam logic [WORD_W-1:0] EE_STEP   = 16'h0101;
  localparam logic [WORD_W-1:0] EE_TARGET = 16'hBABA;

  localparam logic [7:0] OFS_EE_REQ = 8'h00;
  localparam logic [7:0] OFS_SW_SEM = 8'h04;
  localparam logic [7:0] OFS_FW_STS = 8'h08;
  localparam logic [7:0] OFS_SYNC   = 8'h0C;

  localparam int SEM_W = 3;
endpackage

// File: rtl/ee_word_rom.sv
module ee_word_rom
  import eeprom_sema_pkg::*;
#(
  parameter int DEPTH = EE_DEPTH
) (
  input  logic [EE_AW-1:0]  addr_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int LAST = DEPTH - 1;

  function automatic logic [WORD_W-1:0] base_word(input int k);
    logic [31:0] t;
    t = 32'(EE_BASE) + 32'(EE_STEP) * 32'(k);
    return t[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] csum_word();
    logic [WORD_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < LAST; k++) acc = acc + base_word(k);
    return EE_TARGET - acc;
  endfunction

  localparam logic [WORD_W-1:0] CSUM = csum_word();

  always_comb begin
    if (32'(addr_i) < 32'(LAST))       data_o = base_word(int'(addr_i));
    else if (32'(addr_i) == 32'(LAST)) data_o = CSUM;
    else                               data_o = '0;
  end
endmodule

// File: rtl/ee_req_reg.sv
module ee_req_reg
  import eeprom_sema_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] rom_data_i,
  output logic [EE_AW-1:0]  rom_addr_o,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_d;

  assign rom_addr_o = wdata_i[EE_AW+1:2];

  always_comb begin
    q_d = q_o;
    if (wr_i) begin
      if (wdata_i[0]) q_d = {rom_data_i, rom_addr_o, 1'b1, 1'b0};
      else            q_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
endmodule

// File: rtl/sw_sema_reg.sv
module sw_sema_reg
  import eeprom_sema_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [SEM_W-1:0] wdata_i,
  input  logic             fw_sem_i,
  output logic [SEM_W-1:0] q_o
);
  logic [SEM_W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (wr_i)      q_d = {wdata_i[2], wdata_i[1] & ~fw_sem_i, wdata_i[0]};
    else if (rd_i) q_d = q_o | SEM_W'(1);   // taken after being read
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
endmodule

// File: rtl/eeprom_sema_regs.sv
module eeprom_sema_regs
  import eeprom_sema_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  input  logic              fw_sem_i,
  input  logic [2:0]        fw_mode_i,
  input  logic [2:0]        fw_rst_cnt_i
);
  logic sel_ee, sel_sem, sel_fw, sel_sync;
  logic [EE_AW-1:0]  rom_addr;
  logic [WORD_W-1:0] rom_data;
  logic [DATA_W-1:0] ee_q;
  logic [SEM_W-1:0]  sem_q;
  logic [DATA_W-1:0] sync_q;

  assign sel_ee   = addr_i == ADDR_W'(OFS_EE_REQ);
  assign sel_sem  = addr_i == ADDR_W'(OFS_SW_SEM);
  assign sel_fw   = addr_i == ADDR_W'(OFS_FW_STS);
  assign sel_sync = addr_i == ADDR_W'(OFS_SYNC);

  ee_word_rom #(.DEPTH(EE_DEPTH)) u_rom (
    .addr_i (rom_addr),
    .data_o (rom_data)
  );

  ee_req_reg u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (we_i & sel_ee),
    .wdata_i    (wdata_i),
    .rom_data_i (rom_data),
    .rom_addr_o (rom_addr),
    .q_o        (ee_q)
  );

  sw_sema_reg u_sem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (we_i & sel_sem),
    .rd_i     (re_i & sel_sem),
    .wdata_i  (wdata_i[SEM_W-1:0]),
    .fw_sem_i (fw_sem_i),
    .q_o      (sem_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              sync_q <= '0;
    else if (we_i && sel_sync) sync_q <= wdata_i;

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (1'b1)
        sel_ee:   rdata_o = ee_q;
        sel_sem:  rdata_o = 32'(sem_q);
        sel_fw:   rdata_o = {13'd0, fw_rst_cnt_i, 12'd0, fw_mode_i, fw_sem_i};
        sel_sync: rdata_o = sync_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_sema_chk.sv
module eeprom_sema_chk
  import eeprom_sema_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [31:0]       rdata_o,
  input logic              fw_sem_i,
  input logic [31:0]       ee_q,
  input logic [SEM_W-1:0]  sem_q,
  input logic [31:0]       sync_q
);
  logic wr_ee, wr_sem, wr_sync, rd_sem, rd_fw;
  assign wr_ee   = we_i && addr_i == ADDR_W'(OFS_EE_REQ);
  assign wr_sem  = we_i && addr_i == ADDR_W'(OFS_SW_SEM);
  assign wr_sync = we_i && addr_i == ADDR_W'(OFS_SYNC);
  assign rd_sem  = re_i && !we_i && addr_i == ADDR_W'(OFS_SW_SEM);
  assign rd_fw   = re_i && addr_i == ADDR_W'(OFS_FW_STS);

  p_start_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ee && wdata_i[0] |=> ee_q[1] && !ee_q[0] && ee_q[15:2] == $past(wdata_i[15:2]));

  p_oor_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ee && wdata_i[0] && wdata_i[15:2] >= 14'(EE_DEPTH) |=> ee_q[31:16] == 16'd0);

  p_plain_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ee && !wdata_i[0] |=> ee_q == $past(wdata_i));

  p_sem_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sem |=> sem_q[0]);

  p_fw_veto_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sem && fw_sem_i |=> !sem_q[1]);

  p_fw_view_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fw |-> rdata_o[0] == fw_sem_i && rdata_o[15:4] == 12'd0);

  p_sync_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sync |=> sync_q == $past(wdata_i));

  p_idle_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == 32'd0);
endmodule

bind eeprom_sema_regs eeprom_sema_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .fw_sem_i (fw_sem_i),
  .ee_q     (ee_q),
  .sem_q    (sem_q),
  .sync_q   (sync_q)
);

// File: tb/sim_eeprom_sema_regs.sv
module sim_eeprom_sema_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;
  logic        fw_sem_i = 1'b0;
  logic [2:0]  fw_mode_i = 3'd5;
  logic [2:0]  fw_rst_cnt_i = 3'd3;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk_i = ~clk_i;   // 250 MHz

  eeprom_sema_regs u0 (.*);

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'h0,          32'h0,          4'd1},  // R1 request reg at reset
    '{1'b1, 8'h0C, 32'h0,          32'h0,          4'd1},  // R1 sync reg at reset
    '{1'b0, 8'h00, 32'h0000_0015,  32'h0,          4'd2},  // R2 start, addr 5
    '{1'b1, 8'h00, 32'h0,          32'h1505_0016,  4'd2},
    '{1'b0, 8'h00, 32'h0000_0001,  32'h0,          4'd3},  // R3 addr 0
    '{1'b1, 8'h00, 32'h0,          32'h1000_0002,  4'd3},
    '{1'b0, 8'h00, 32'h0000_00F9,  32'h0,          4'd3},  // R3 addr 62
    '{1'b1, 8'h00, 32'h0,          32'h4E3E_00FA,  4'd3},
    '{1'b0, 8'h00, 32'h0000_00FD,  32'h0,          4'd3},  // R3 checksum word 63
    '{1'b1, 8'h00, 32'h0,          32'h2219_00FE,  4'd3},
    '{1'b0, 8'h00, 32'hFFFF_0101,  32'h0,          4'd4},  // R4 addr 64
    '{1'b1, 8'h00, 32'h0,          32'h0000_0102,  4'd4},
    '{1'b0, 8'h00, 32'h0000_FFFD,  32'h0,          4'd4},  // R4 max addr
    '{1'b1, 8'h00, 32'h0,          32'h0000_FFFE,  4'd4},
    '{1'b0, 8'h00, 32'hABCD_0122,  32'h0,          4'd5},  // R5 no start
    '{1'b1, 8'h00, 32'h0,          32'hABCD_0122,  4'd5},
    '{1'b0, 8'h0C, 32'hDEAD_BEEF,  32'h0,          4'd9},  // R9
    '{1'b1, 8'h0C, 32'h0,          32'hDEAD_BEEF,  4'd9},
    '{1'b0, 8'h0C, 32'h1234_5678,  32'h0,          4'd9},
    '{1'b1, 8'h0C, 32'h0,          32'h1234_5678,  4'd9},
    '{1'b1, 8'h08, 32'h0,          32'h0003_000A,  4'd8},  // R8 mode 5, count 3
    '{1'b0, 8'h08, 32'hFFFF_FFFF,  32'h0,          4'd8},  // R8 write ignored
    '{1'b1, 8'h08, 32'h0,          32'h0003_000A,  4'd8},
    '{1'b1, 8'h10, 32'h0,          32'h0,          4'd10}  // R10 unmapped
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #1;
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    #1 d = rdata_o;
    @(posedge clk_i); #1;
    re_i = 1'b0;
  endtask

  function automatic logic [15:0] model_word(input int k);
    logic [31:0] t;
    logic [15:0] acc;
    if (k < 63) begin
      t = 32'h1000 + 32'h0101 * 32'(k);
      return t[15:0];
    end
    acc = '0;
    for (int j = 0; j < 63; j++) acc = acc + model_word(j);
    return 16'hBABA - acc;
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [15:0] sum;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 semaphore reads 0 after reset; R6 then taken
    rd(8'h04, r); check(1, r, 32'h0);
    rd(8'h04, r); check(6, r, 32'h1);

    foreach (VECS[i]) begin
      if (VECS[i].is_rd) begin
        rd(VECS[i].addr, r);
        check(int'(VECS[i].req), r, VECS[i].exp);
      end else begin
        wr(VECS[i].addr, VECS[i].wdata);
      end
    end

    // R10 idle bus reads 0 with a valid address
    @(negedge clk_i); addr_i = 8'h0C; #1 check(10, rdata_o, 32'h0);

    // R3 whole array against formula and checksum target
    sum = '0;
    for (int k = 0; k < 64; k++) begin
      wr(8'h00, (32'(k) << 2) | 32'h1);
      rd(8'h00, r);
      sum = sum + r[31:16];
      if (r[31:16] !== model_word(k)) check(3, 32'(r[31:16]), 32'(model_word(k)));
    end
    check(3, 32'(sum), 32'h0000_BABA);

    // R7 store bits 2:0 when firmware free; R6 read sets bit 0
    fw_sem_i = 1'b0;
    wr(8'h04, 32'hFFFF_FFF6);
    rd(8'h04, r); check(7, r, 32'h6);
    rd(8'h04, r); check(6, r, 32'h7);
    // R7 firmware holds: bit 1 forced 0
    fw_sem_i = 1'b1;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, r); check(7, r, 32'h5);
    wr(8'h04, 32'h0000_0002);
    rd(8'h04, r); check(7, r, 32'h0);
    // R8 firmware semaphore visible in bit 0
    fw_mode_i = 3'd2; fw_rst_cnt_i = 3'd7;
    rd(8'h08, r); check(8, r, 32'h0007_0005);

    // R1 mid-run reset clears all registers
    wr(8'h0C, 32'hCAFE_F00D);
    wr(8'h00, 32'h0000_0015);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd(8'h0C, r); check(1, r, 32'h0);
    rd(8'h00, r); check(1, r, 32'h0);
    rd(8'h04, r); check(1, r, 32'h0);

    finish_run();
  end
endmodule